// File: doc/BRIEF.md
# Receive Descriptor Prefetch Cache

This block sits beside a receive DMA engine. It keeps a small on-chip store of free-buffer descriptors so that the engine does not wait on host memory each time it needs a buffer. The descriptors come from circular queues in host memory. One queue holds large-buffer descriptors. A second, optional queue holds small-buffer descriptors. Each descriptor is 64 bits wide, made of two 32-bit words. All queue addresses and pointers count whole descriptors.

When the local count for a queue falls to its low-water mark, the block compares its own read pointer with the host's write pointer. It then asks a generic memory-read port for a burst. The burst is as long as the refill allows without overtaking the host, and it never crosses the queue's end address. The response beats are stored, one per descriptor. After the last beat the read pointer moves forward, and a sticky status flag records the fetch. If the host queue is empty, an error flag is raised instead, and nothing else changes. Consumers pop descriptors for each buffer size from a show-ahead interface.

The store holds 16 descriptors. In single mode it is one 16-entry FIFO. In dual mode it splits into two independent 8-entry halves, one for each buffer size.

Top module: `dpf_prefetch`

## Requirements
- R1: After reset, `req_valid`, `lg_valid`, `sm_valid`, `stat` and `irq` are all zero.
- R2: Dual mode is in force while `cfg_sm_start` differs from `cfg_q_end`; otherwise only the large queue exists. In single mode the block never requests for the small queue, and `sm_valid` stays low.
- R3: The large FIFO holds 16 descriptors in single mode and 8 in dual mode; the small FIFO holds 8. A refill is considered only while `pf_en` is high, no burst is in flight, and the queue's local count is at or below the low-water mark (4 in single mode, 2 in dual mode).
- R4: A request carries the queue's read pointer in `req_addr` and sets `req_len` to the smallest of three values: the free local slots, the host descriptors between the read pointer and the host write pointer, and the descriptors left before the queue end address.
- R5: If a refill is due and the host write pointer equals the read pointer, the error flag for that queue is set, no request is made, and the read pointer keeps its value.
- R6: After the last response beat, the read pointer moves forward by `req_len` and wraps to the start address once it passes the end address, and the done flag for that queue is set. The large queue spans `cfg_lg_start`..`cfg_lg_end`; the small queue spans `cfg_sm_start`..`cfg_q_end`.
- R7: At most one burst is in flight at a time. When both queues are due together, the large queue is requested first. `req_queue` is 0 for the large queue and 1 for the small queue.
- R8: Each FIFO pops in arrival order. `lg_desc`/`sm_desc` show the head whenever the matching valid is high. A pop on an empty FIFO is ignored, and the valid stays low.
- R9: The bits of `stat` are: bit 0 large done, bit 1 small done, bit 2 large error, bit 3 small error. Each bit stays set until a 1 is written to the same bit of `stat_clr`. `irq` is high when any set bit of `stat` has its `irq_en` bit set.
- R10: While `pf_en` is low, both FIFOs are emptied, the read pointers reload from the start addresses, and no request is raised. While `req_valid` is high and `req_ready` is low, the request fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_en | input | 1 | Prefetch enable; low flushes and reloads the pointers |
| cfg_lg_start | input | IDX_W | First descriptor slot of the large queue |
| cfg_lg_end | input | IDX_W | Last descriptor slot of the large queue |
| cfg_sm_start | input | IDX_W | First descriptor slot of the small queue |
| cfg_q_end | input | IDX_W | Overall end slot; also the last slot of the small queue |
| host_wr_lg | input | IDX_W | Host write pointer of the large queue |
| host_wr_sm | input | IDX_W | Host write pointer of the small queue |
| req_valid | output | 1 | Burst read request pending |
| req_ready | input | 1 | Memory side accepts the request |
| req_queue | output | 1 | Queue being fetched (0 large, 1 small) |
| req_addr | output | IDX_W | First descriptor slot of the burst |
| req_len | output | LEN_W | Number of descriptors in the burst |
| rsp_valid | input | 1 | One descriptor beat is present |
| rsp_data | input | DESC_W | Descriptor beat |
| pop_lg | input | 1 | Consume the large-FIFO head |
| lg_valid | output | 1 | Large FIFO is not empty |
| lg_desc | output | DESC_W | Large-FIFO head |
| pop_sm | input | 1 | Consume the small-FIFO head |
| sm_valid | output | 1 | Small FIFO is not empty |
| sm_desc | output | DESC_W | Small-FIFO head |
| stat | output | 4 | Sticky status flags |
| stat_clr | input | 4 | Write-one-to-clear strobes for `stat` |
| irq_en | input | 4 | Interrupt enable for each status bit |
| irq | output | 1 | Interrupt request |

## Verification
The refill path is driven with host pointers chosen so that each bound on the burst length in turn is the one that decides: a host queue deeper than the FIFO (the free-slot bound), a host queue that is only a few entries ahead (the host-pointer bound), and a pointer that must wrap past the end address (the end-of-queue bound). An empty host queue is used both before and after fetches. The next request address then shows whether the pointer stayed where it was. A dual-mode run with both queues due at once tells apart the priority order, the 8-entry cap and the lower low-water mark. Pops on an empty FIFO and partial clears of the status flags show that ignored inputs leave the outputs as they were.

// File: rtl/dpf_pkg.sv
// Shared types for the descriptor prefetch cache.
// Assumes: nothing beyond the standard language.
package dpf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2
    } dpf_state_t;

    localparam int STAT_LG_DONE = 0;
    localparam int STAT_SM_DONE = 1;
    localparam int STAT_LG_ERR  = 2;
    localparam int STAT_SM_ERR  = 3;
endpackage

// File: rtl/dpf_fifo_ctl.sv
// Pointer and count keeper for one FIFO that lives in a window of a shared
// store. The window starts at 'base' and is 'cap' entries long.
// Assumes: the caller never pushes into a full window, and 'cap' only
// changes while 'flush' is high.
module dpf_fifo_ctl #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [PTR_W-1:0] base,
    input  logic [CNT_W-1:0] cap,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx,
    output logic [CNT_W-1:0] count
);
    logic [PTR_W-1:0] wr_off, rd_off;
    logic             pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] off,
                                              input logic [CNT_W-1:0] lim);
        if (CNT_W'(off) + CNT_W'(1) == lim) return '0;
        return off + PTR_W'(1);
    endfunction

    // Accept pops only when data is present and pushes only when there is room.
    assign pop_ok  = pop && (count != '0);
    assign push_ok = push && (count != cap);

    // Move the offsets and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_off <= '0;
            rd_off <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_off <= step(wr_off, cap);
            if (pop_ok)  rd_off <= step(rd_off, cap);
            if (push_ok && !pop_ok)      count <= count + CNT_W'(1);
            else if (pop_ok && !push_ok) count <= count - CNT_W'(1);
        end
    end

    assign wr_idx = base + wr_off;
    assign rd_idx = base + rd_off;
endmodule

// File: rtl/dpf_span.sv
// Host-queue arithmetic for one circular queue. It gives the number of
// descriptors that can be read in one straight run from the read pointer
// (stopping at the host write pointer or at the queue end), and the read
// pointer after 'adv' descriptors have been read.
// Assumes: rd, wr and q_start lie within q_start..q_end, and adv never
// exceeds the run.
module dpf_span #(
    parameter int IDX_W = 12,
    parameter int LEN_W = 5
) (
    input  logic [IDX_W-1:0] q_start,
    input  logic [IDX_W-1:0] q_end,
    input  logic [IDX_W-1:0] rd,
    input  logic [IDX_W-1:0] wr,
    input  logic [LEN_W-1:0] adv,
    output logic [IDX_W:0]   run,
    output logic [IDX_W-1:0] rd_next
);
    logic [IDX_W:0] sum;

    // Straight-run length up to the host pointer or the queue end.
    always_comb begin
        if (wr >= rd) run = {1'b0, wr} - {1'b0, rd};
        else          run = {1'b0, q_end} + (IDX_W+1)'(1) - {1'b0, rd};
    end

    // Advanced pointer, wrapping to the start past the end.
    always_comb begin
        sum     = {1'b0, rd} + (IDX_W+1)'(adv);
        rd_next = (sum > {1'b0, q_end}) ? q_start : sum[IDX_W-1:0];
    end
endmodule

// File: rtl/dpf_prefetch.sv
// Receive descriptor prefetch cache. It keeps a shared store of DEPTH
// descriptors. The store is one FIFO for the large queue, or two half-size
// FIFOs when a small queue is configured. Each FIFO is refilled by burst
// reads from a host circular queue.
// Assumes: pf_en is held low for at least one cycle after reset and while
// the configuration changes, and memory responses arrive only for the
// accepted request, one descriptor per beat.
module dpf_prefetch
    import dpf_pkg::*;
#(
    parameter int IDX_W      = 12,
    parameter int DESC_W     = 64,
    parameter int DEPTH      = 16,
    parameter int LEN_W      = $clog2(DEPTH + 1),
    parameter int LWM_SINGLE = 4,
    parameter int LWM_DUAL   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_en,
    input  logic [IDX_W-1:0]  cfg_lg_start,
    input  logic [IDX_W-1:0]  cfg_lg_end,
    input  logic [IDX_W-1:0]  cfg_sm_start,
    input  logic [IDX_W-1:0]  cfg_q_end,
    input  logic [IDX_W-1:0]  host_wr_lg,
    input  logic [IDX_W-1:0]  host_wr_sm,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_queue,
    output logic [IDX_W-1:0]  req_addr,
    output logic [LEN_W-1:0]  req_len,
    input  logic              rsp_valid,
    input  logic [DESC_W-1:0] rsp_data,
    input  logic              pop_lg,
    output logic              lg_valid,
    output logic [DESC_W-1:0] lg_desc,
    input  logic              pop_sm,
    output logic              sm_valid,
    output logic [DESC_W-1:0] sm_desc,
    output logic [3:0]        stat,
    input  logic [3:0]        stat_clr,
    input  logic [3:0]        irq_en,
    output logic              irq
);
    localparam int HALF  = DEPTH / 2;
    localparam int PTR_W = $clog2(DEPTH);

    dpf_state_t        st;
    logic              cur_q;
    logic [IDX_W-1:0]  rd_lg, rd_sm, addr_r, nxt_lg, nxt_sm;
    logic [LEN_W-1:0]  len_r, left, cnt_lg, cnt_sm, cap_lg, lwm, free_lg, free_sm;
    logic [IDX_W:0]    run_lg, run_sm;
    logic [PTR_W-1:0]  widx_lg, ridx_lg, widx_sm, ridx_sm;
    logic              dual, idle, due_lg, due_sm, go_lg, go_sm, err_lg, err_sm;
    logic              beat, last;
    logic [3:0]        stat_r, stat_set;
    logic [DESC_W-1:0] store [DEPTH];

    function automatic logic [LEN_W-1:0] clamp(input logic [IDX_W:0] run,
                                               input logic [LEN_W-1:0] room);
        if (run < (IDX_W+1)'(room)) return LEN_W'(run);
        return room;
    endfunction

    // Mode, capacity and refill decisions for both queues.
    always_comb begin
        dual    = (cfg_sm_start != cfg_q_end);
        cap_lg  = dual ? LEN_W'(HALF) : LEN_W'(DEPTH);
        lwm     = dual ? LEN_W'(LWM_DUAL) : LEN_W'(LWM_SINGLE);
        free_lg = cap_lg - cnt_lg;
        free_sm = LEN_W'(HALF) - cnt_sm;
        idle    = (st == ST_IDLE);
        due_lg  = pf_en && idle && (cnt_lg <= lwm);
        due_sm  = pf_en && idle && dual && (cnt_sm <= lwm);
        go_lg   = due_lg && (run_lg != '0);
        go_sm   = due_sm && (run_sm != '0) && !go_lg;
        err_lg  = due_lg && (run_lg == '0);
        err_sm  = due_sm && (run_sm == '0);
        beat    = (st == ST_DATA) && rsp_valid;
        last    = beat && (left == LEN_W'(1));
    end

    dpf_span #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_span_lg (
        .q_start(cfg_lg_start), .q_end(cfg_lg_end), .rd(rd_lg), .wr(host_wr_lg),
        .adv(len_r), .run(run_lg), .rd_next(nxt_lg)
    );

    dpf_span #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_span_sm (
        .q_start(cfg_sm_start), .q_end(cfg_q_end), .rd(rd_sm), .wr(host_wr_sm),
        .adv(len_r), .run(run_sm), .rd_next(nxt_sm)
    );

    dpf_fifo_ctl #(.DEPTH(DEPTH), .CNT_W(LEN_W), .PTR_W(PTR_W)) u_fifo_lg (
        .clk(clk), .rst_n(rst_n), .flush(!pf_en), .base('0), .cap(cap_lg),
        .push(beat && !cur_q), .pop(pop_lg),
        .wr_idx(widx_lg), .rd_idx(ridx_lg), .count(cnt_lg)
    );

    dpf_fifo_ctl #(.DEPTH(DEPTH), .CNT_W(LEN_W), .PTR_W(PTR_W)) u_fifo_sm (
        .clk(clk), .rst_n(rst_n), .flush(!pf_en), .base(PTR_W'(HALF)),
        .cap(LEN_W'(HALF)), .push(beat && cur_q), .pop(pop_sm),
        .wr_idx(widx_sm), .rd_idx(ridx_sm), .count(cnt_sm)
    );

    // Request sequencer: choose a queue, hold the request, count the beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cur_q  <= 1'b0;
            addr_r <= '0;
            len_r  <= '0;
            left   <= '0;
        end else if (!pf_en) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (go_lg) begin
                        st     <= ST_REQ;
                        cur_q  <= 1'b0;
                        addr_r <= rd_lg;
                        len_r  <= clamp(run_lg, free_lg);
                        left   <= clamp(run_lg, free_lg);
                    end else if (go_sm) begin
                        st     <= ST_REQ;
                        cur_q  <= 1'b1;
                        addr_r <= rd_sm;
                        len_r  <= clamp(run_sm, free_sm);
                        left   <= clamp(run_sm, free_sm);
                    end
                end
                ST_REQ: if (req_ready) st <= ST_DATA;
                ST_DATA: begin
                    if (beat) left <= left - LEN_W'(1);
                    if (last) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Read pointers: reload while disabled, advance after a finished burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_lg <= '0;
            rd_sm <= '0;
        end else if (!pf_en) begin
            rd_lg <= cfg_lg_start;
            rd_sm <= cfg_sm_start;
        end else if (last) begin
            if (cur_q) rd_sm <= nxt_sm;
            else       rd_lg <= nxt_lg;
        end
    end

    // Shared descriptor store, written one beat at a time.
    always_ff @(posedge clk) begin
        if (beat) store[cur_q ? widx_sm : widx_lg] <= rsp_data;
    end

    // Sticky status flags; a new event wins over a clear in the same cycle.
    always_comb begin
        stat_set               = '0;
        stat_set[STAT_LG_DONE] = last && !cur_q;
        stat_set[STAT_SM_DONE] = last && cur_q;
        stat_set[STAT_LG_ERR]  = err_lg;
        stat_set[STAT_SM_ERR]  = err_sm;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_r <= '0;
        else        stat_r <= (stat_r & ~stat_clr) | stat_set;
    end

    assign req_valid = (st == ST_REQ);
    assign req_queue = cur_q;
    assign req_addr  = addr_r;
    assign req_len   = len_r;
    assign lg_valid  = (cnt_lg != '0);
    assign sm_valid  = (cnt_sm != '0);
    assign lg_desc   = store[ridx_lg];
    assign sm_desc   = store[ridx_sm];
    assign stat      = stat_r;
    assign irq       = |(stat_r & irq_en);
endmodule

// File: rtl/dpf_prefetch_chk.sv
// Temporal checks on the ports of the prefetch cache, bound to every instance.
// Assumes: the same parameter values as the instance it is bound to.
module dpf_prefetch_chk #(
    parameter int IDX_W = 12,
    parameter int LEN_W = 5,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pf_en,
    input logic [IDX_W-1:0] cfg_lg_end,
    input logic [IDX_W-1:0] cfg_sm_start,
    input logic [IDX_W-1:0] cfg_q_end,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_queue,
    input logic [IDX_W-1:0] req_addr,
    input logic [LEN_W-1:0] req_len,
    input logic [3:0]       stat,
    input logic [3:0]       stat_clr
);
    logic             in_dual;
    logic [IDX_W+1:0] lg_reach, lg_limit, sm_reach, sm_limit;
    logic [LEN_W-1:0] cap_now;

    assign in_dual  = (cfg_sm_start != cfg_q_end);
    assign cap_now  = in_dual ? LEN_W'(DEPTH / 2) : LEN_W'(DEPTH);
    assign lg_reach = (IDX_W+2)'(req_addr) + (IDX_W+2)'(req_len);
    assign lg_limit = (IDX_W+2)'(cfg_lg_end) + (IDX_W+2)'(1);
    assign sm_reach = lg_reach;
    assign sm_limit = (IDX_W+2)'(cfg_q_end) + (IDX_W+2)'(1);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_queue)); // R10
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !pf_en |=> !req_valid); // R10
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) req_valid |-> (req_len != '0) && (req_len <= cap_now)); // R4
    AST_SINGLE_LG_ONLY: assert property (@(posedge clk) disable iff (!rst_n) req_valid && !in_dual |-> !req_queue); // R2
    AST_LG_IN_QUEUE: assert property (@(posedge clk) disable iff (!rst_n) req_valid && !req_queue |-> lg_reach <= lg_limit); // R6
    AST_SM_IN_QUEUE: assert property (@(posedge clk) disable iff (!rst_n) req_valid && req_queue |-> sm_reach <= sm_limit); // R6
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (|(stat & ~stat_clr)) |=> ((stat & $past(stat & ~stat_clr)) == $past(stat & ~stat_clr))); // R9
endmodule

bind dpf_prefetch dpf_prefetch_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_dpf_prefetch.sv
// Self-checking bench for the descriptor prefetch cache on a small configuration.
module tb_dpf_prefetch;
    localparam int IDX_W  = 8;
    localparam int DESC_W = 64;
    localparam int DEPTH  = 16;
    localparam int LEN_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n, pf_en, req_ready, rsp_valid, pop_lg, pop_sm;
    logic [IDX_W-1:0]  cfg_lg_start, cfg_lg_end, cfg_sm_start, cfg_q_end;
    logic [IDX_W-1:0]  host_wr_lg, host_wr_sm, req_addr;
    logic              req_valid, req_queue, lg_valid, sm_valid, irq;
    logic [LEN_W-1:0]  req_len;
    logic [DESC_W-1:0] rsp_data, lg_desc, sm_desc;
    logic [3:0]        stat, stat_clr, irq_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    dpf_prefetch #(.IDX_W(IDX_W), .DESC_W(DESC_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .pf_en(pf_en),
        .cfg_lg_start(cfg_lg_start), .cfg_lg_end(cfg_lg_end),
        .cfg_sm_start(cfg_sm_start), .cfg_q_end(cfg_q_end),
        .host_wr_lg(host_wr_lg), .host_wr_sm(host_wr_sm),
        .req_valid(req_valid), .req_ready(req_ready), .req_queue(req_queue),
        .req_addr(req_addr), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .pop_lg(pop_lg), .lg_valid(lg_valid), .lg_desc(lg_desc),
        .pop_sm(pop_sm), .sm_valid(sm_valid), .sm_desc(sm_desc),
        .stat(stat), .stat_clr(stat_clr), .irq_en(irq_en), .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic logic [63:0] mk(input logic q, input logic [IDX_W-1:0] idx);
        return {24'hD35C00, 7'd0, q, 24'h0, idx};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Wait for a request, check its fields, optionally stall it, then answer it.
    task automatic serve(input logic q, input logic [IDX_W-1:0] addr,
                         input int len, input int hold, input string req);
        int t = 0;
        while (!req_valid && t < 60) begin
            @(negedge clk);
            t++;
        end
        check(req_valid, req, "request raised", 64'(req_valid), 64'd1);
        if (!req_valid) return;
        check(req_queue == q, req, "req_queue", 64'(req_queue), 64'(q));
        check(req_addr == addr, req, "req_addr", 64'(req_addr), 64'(addr));
        check(req_len == LEN_W'(len), req, "req_len", 64'(req_len), 64'(len));
        if (hold > 0) begin
            req_ready = 1'b0;
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                check(req_valid && req_addr == addr, "R10", "held request", 64'(req_addr), 64'(addr));
            end
            req_ready = 1'b1;
        end
        @(posedge clk);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rsp_valid = 1'b1;
            rsp_data  = mk(q, IDX_W'(int'(addr) + i));
        end
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    // Pop n descriptors and compare each with the expected host slot.
    task automatic pop_chk(input logic q, input logic [IDX_W-1:0] first, input int n,
                           input logic [IDX_W-1:0] qs, input logic [IDX_W-1:0] qe);
        logic [IDX_W-1:0] e = first;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (q) begin
                check(sm_valid && sm_desc == mk(1'b1, e), "R8", "small head", sm_desc, mk(1'b1, e));
                pop_sm = 1'b1;
            end else begin
                check(lg_valid && lg_desc == mk(1'b0, e), "R8", "large head", lg_desc, mk(1'b0, e));
                pop_lg = 1'b1;
            end
            e = (e == qe) ? qs : e + IDX_W'(1);
        end
        @(negedge clk);
        pop_lg = 1'b0;
        pop_sm = 1'b0;
    endtask

    task automatic no_req(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(!req_valid, req, "no request", 64'(req_valid), 64'd0);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; pf_en = 1'b0; req_ready = 1'b1; rsp_valid = 1'b0; rsp_data = '0;
        pop_lg = 1'b0; pop_sm = 1'b0; stat_clr = '0; irq_en = '0;
        cfg_lg_start = 8'd0; cfg_lg_end = 8'd31; cfg_sm_start = 8'd31; cfg_q_end = 8'd31;
        host_wr_lg = 8'd0; host_wr_sm = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check(!req_valid && !lg_valid && !sm_valid, "R1", "outputs idle", {req_valid, lg_valid, sm_valid}, 0);
        check(stat == 4'h0 && !irq, "R1", "status clear", {irq, stat}, 0);

        // Single mode, empty host queue: error and no request (R5)
        pf_en = 1'b1;
        no_req(5, "R5");
        check(stat == 4'b0100, "R5", "large error flag", stat, 4'b0100);
        irq_en = 4'b0100;
        #1 check(irq, "R9", "irq enabled", irq, 1);
        irq_en = 4'b1011;
        #1 check(!irq, "R9", "irq masked", irq, 0);

        // Host deeper than the FIFO: free-slot bound, cap 16 (R3, R4)
        host_wr_lg = 8'd20;
        stat_clr = 4'hF;
        @(negedge clk);
        stat_clr = 4'h0;
        check(stat == 4'b0000, "R9", "clear all", stat, 0);
        serve(1'b0, 8'd0, 16, 0, "R4");
        check(stat == 4'b0001, "R6", "large done flag", stat, 4'b0001);
        check(!sm_valid, "R2", "no small data in single mode", sm_valid, 0);
        pop_chk(1'b0, 8'd0, 11, 8'd0, 8'd31);
        no_req(3, "R3");
        pop_chk(1'b0, 8'd11, 1, 8'd0, 8'd31);
        serve(1'b0, 8'd16, 4, 0, "R4");
        pop_chk(1'b0, 8'd12, 8, 8'd0, 8'd31);
        repeat (2) @(negedge clk);
        check(stat == 4'b0101, "R5", "error after draining host", stat, 4'b0101);

        // Pointer kept at 20 after errors; end-of-queue bound, then wrap (R5, R6)
        host_wr_lg = 8'd5;
        serve(1'b0, 8'd20, 12, 0, "R5");
        pop_chk(1'b0, 8'd20, 8, 8'd0, 8'd31);
        serve(1'b0, 8'd0, 5, 0, "R6");
        pop_chk(1'b0, 8'd28, 9, 8'd0, 8'd31);
        stat_clr = 4'b0001;
        @(negedge clk);
        stat_clr = 4'h0;
        check(stat == 4'b0100, "R9", "partial clear", stat, 4'b0100);

        // Flush on disable, then dual mode (R10, R2, R7)
        pf_en = 1'b0;
        @(negedge clk);
        check(!lg_valid && !req_valid, "R10", "flushed while disabled", {lg_valid, req_valid}, 0);
        cfg_lg_end = 8'd15; cfg_sm_start = 8'd16; cfg_q_end = 8'd31;
        host_wr_lg = 8'd10; host_wr_sm = 8'd19;
        stat_clr = 4'hF;
        @(negedge clk);
        stat_clr = 4'h0;
        pf_en = 1'b1;
        serve(1'b0, 8'd0, 8, 3, "R7");
        serve(1'b1, 8'd16, 3, 0, "R7");
        check(stat == 4'b0011, "R6", "both done flags", stat, 4'b0011);
        pop_chk(1'b1, 8'd16, 3, 8'd16, 8'd31);
        @(negedge clk);
        pop_sm = 1'b1;
        check(!sm_valid, "R8", "small empty before pop", sm_valid, 0);
        @(negedge clk);
        pop_sm = 1'b0;
        check(!sm_valid, "R8", "empty pop ignored", sm_valid, 0);
        repeat (2) @(negedge clk);
        check(stat[3], "R5", "small error flag", stat, 4'b1011);

        // Dual-mode low-water mark and host-pointer bound (R3, R4)
        pop_chk(1'b0, 8'd0, 5, 8'd0, 8'd15);
        no_req(3, "R3");
        pop_chk(1'b0, 8'd5, 1, 8'd0, 8'd15);
        serve(1'b0, 8'd8, 2, 0, "R4");
        pop_chk(1'b0, 8'd6, 4, 8'd0, 8'd15);
        repeat (2) @(negedge clk);
        check(stat[2] && !lg_valid, "R5", "large error after drain", stat, 4'b1111);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end
endmodule